// File: doc/BRIEF.md
# Nonvolatile Write Request Sequencer

This block sits between a bus master and a nonvolatile memory array. It takes single-word programs, half-page programs and mass-erase requests. It decides what happens to a new write that arrives while an earlier operation is still in progress. A counter stands in for the array's program and erase time. When an operation is launched, the block gives the array one start pulse with the operation code, the address and all of the data words.

Each write request is checked against a per-sector protection map once all of its data has arrived. A write that hits a protected sector is taken off the bus at once and thrown away, and a sticky error flag is set. A write that arrives while a program is running is held: the master's ready stays low until the running program ends. The held write then starts in that same cycle, so busy never drops between the two operations. During a mass erase, neither write beats nor configuration writes are taken, which keeps the protection map safe from stray updates. Configuration writes are stalled only during a mass erase or while a half-page burst is partly loaded.

Top module: `nvs_write_seq`

## Requirements
- R1: After reset the block is not busy, not erasing, nothing is held, the error flag is clear, no start pulse is given, every sector is writable, and both `wr_ready` and `cfg_ready` are high.
- R2: A single-word program is any `wr_op` code other than 1 or 2. At idle it is accepted with no stall. In the next cycle `nvm_start` pulses with `nvm_op`=0, `nvm_addr` equal to the request address, word 0 of `nvm_wdata` equal to the data and all other words zero. `busy` then stays high for exactly PROG_CYCLES cycles.
- R3: A half-page program (`wr_op`=1) is a burst of HP_WORDS beats, and its address is the first beat's address. Every beat before the last is accepted with no stall, even while a program runs. Once a burst has started, each beat counts as its next word, whatever its code. After the last beat, `nvm_op`=1 and beat i appears at `nvm_wdata[i*DATA_W +: DATA_W]`.
- R4: A request's sector is the top SECT_W bits of its address. When the last beat of a request hits a protected sector, that beat is accepted without stall and no operation is launched. `wrp_err` goes high in the next cycle, and `busy` keeps the value it had.
- R5: While a program runs, the last beat of an unprotected write is stalled and `held` goes high. The write is accepted and launched in the cycle the running program finishes, and `busy` stays high without a gap.
- R6: A mass erase (`wr_op`=2) is accepted only when the block is idle and no burst is partly loaded. It pulses `nvm_start` with `nvm_op`=2, and `erasing` and `busy` stay high for ERASE_CYCLES cycles.
- R7: While `erasing` is high, no write beat and no configuration write is accepted.
- R8: A configuration write with `cfg_sel`=0 loads the protection map, where bit s protects sector s. It is accepted at once while a program runs, and it stalls while a half-page burst is partly loaded.
- R9: `wrp_err` is sticky. Only a configuration write with `cfg_sel`=1 and bit 0 set clears it, and writing 0 to that bit leaves it set.
- R10: A mass-erase request made while a program runs is stalled until the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Write beat valid |
| wr_op | input | 2 | 0 single word, 1 half-page word, 2 mass erase |
| wr_addr | input | ADDR_W | Beat address |
| wr_data | input | DATA_W | Beat data |
| wr_ready | output | 1 | Beat accepted when high with wr_valid |
| cfg_valid | input | 1 | Configuration write valid |
| cfg_sel | input | 1 | 0 protection map, 1 status clear |
| cfg_wdata | input | 2**SECT_W | Configuration write data |
| cfg_ready | output | 1 | Configuration write accepted |
| busy | output | 1 | An operation is running |
| erasing | output | 1 | Mass erase in progress |
| held | output | 1 | A write is stalled waiting for the array |
| wrp_err | output | 1 | Sticky protection error |
| nvm_start | output | 1 | One-cycle launch pulse to the array |
| nvm_op | output | 2 | Launched operation code |
| nvm_addr | output | ADDR_W | Launched address |
| nvm_wdata | output | HP_WORDS*DATA_W | Launched data words |

## Verification
Some properties are checked on every cycle. No write or configuration beat is accepted during an erase. The error flag stays set until the clear write arrives. A held write always comes with a running operation, and busy is still high in the cycle after a hold. A dropped write leaves busy unchanged. An erase starts only from idle. The timer is never restarted while it is counting, and the burst buffer never overflows. Only the directed scenarios can show the exact stall lengths. These cover a held write waiting PROG_CYCLES-1 cycles, a burst final word waiting PROG_CYCLES-HP_WORDS cycles, and erase stalls of ERASE_CYCLES. The scenarios also check the data placement on the array port and the write-1-to-clear behaviour of the error flag.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [1:0] {
        OP_SINGLE = 2'd0,
        OP_HALF   = 2'd1,
        OP_ERASE  = 2'd2,
        OP_RSVD   = 2'd3
    } nvs_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } nvs_state_e;
endpackage

// File: rtl/nvs_op_timer.sv
module nvs_op_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign done = tmr_q.run && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.run) begin
            if (tmr_q.cnt != '0) tmr_d.cnt = tmr_q.cnt - 1'b1;
            else                 tmr_d.run = 1'b0;
        end
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    AST_TIMER_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (!tmr_q.run || done)); // R5
endmodule

// File: rtl/nvs_load_buf.sv
module nvs_load_buf #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int HP_WORDS = 4,
    localparam int IDX_W   = (HP_WORDS > 1) ? $clog2(HP_WORDS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                push,
    input  logic                                clear,
    input  logic [ADDR_W-1:0]                   addr_in,
    input  logic [DATA_W-1:0]                   word_in,
    output logic [IDX_W-1:0]                    cnt,
    output logic [ADDR_W-1:0]                   base_addr,
    output logic [HP_WORDS-2:0][DATA_W-1:0]     words
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HP_WORDS - 1);

    typedef struct packed {
        logic [IDX_W-1:0]                cnt;
        logic [ADDR_W-1:0]               base;
        logic [HP_WORDS-2:0][DATA_W-1:0] words;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (push) begin
            buf_d.words[buf_q.cnt] = word_in;
            if (buf_q.cnt == '0) buf_d.base = addr_in;
            buf_d.cnt = buf_q.cnt + 1'b1;
        end
        if (clear) buf_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign cnt       = buf_q.cnt;
    assign base_addr = buf_q.base;
    assign words     = buf_q.words;

    AST_BUF_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (buf_q.cnt < LAST_IDX)); // R3
endmodule

// File: rtl/nvs_prot_check.sv
module nvs_prot_check #(
    parameter int SECT_W  = 3,
    localparam int NUM_SECT = 1 << SECT_W
) (
    input  logic [SECT_W-1:0]   sector,
    input  logic [NUM_SECT-1:0] prot_map,
    output logic                hit
);
    logic [NUM_SECT-1:0] sel;

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        localparam logic [SECT_W-1:0] SID = SECT_W'(s);
        assign sel[s] = (sector == SID);
    end

    assign hit = |(sel & prot_map);
endmodule

// File: rtl/nvs_write_seq.sv
module nvs_write_seq
    import nvs_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 32,
    parameter int HP_WORDS     = 4,
    parameter int SECT_W       = 3,
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 40,
    localparam int NUM_SECT    = 1 << SECT_W,
    localparam int IDX_W       = (HP_WORDS > 1) ? $clog2(HP_WORDS) : 1,
    localparam int MAX_CYC     = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
    localparam int CNT_W       = $clog2(MAX_CYC + 1),
    localparam int WIDE_W      = HP_WORDS * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [1:0]          wr_op,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                wr_ready,
    input  logic                cfg_valid,
    input  logic                cfg_sel,
    input  logic [NUM_SECT-1:0] cfg_wdata,
    output logic                cfg_ready,
    output logic                busy,
    output logic                erasing,
    output logic                held,
    output logic                wrp_err,
    output logic                nvm_start,
    output logic [1:0]          nvm_op,
    output logic [ADDR_W-1:0]   nvm_addr,
    output logic [WIDE_W-1:0]   nvm_wdata
);
    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(HP_WORDS - 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

    typedef struct packed {
        nvs_state_e          state;
        logic [NUM_SECT-1:0] prot;
        logic                err;
        logic                held;
        logic                start;
        nvs_op_e             op;
        logic [ADDR_W-1:0]   addr;
        logic [WIDE_W-1:0]   wdata;
    } seq_t;

    seq_t seq_d, seq_q;

    // datapath helpers
    logic                            tmr_done, tmr_start;
    logic [CNT_W-1:0]                tmr_load;
    logic                            buf_push, buf_clear;
    logic [IDX_W-1:0]                buf_cnt;
    logic [ADDR_W-1:0]               buf_base;
    logic [HP_WORDS-2:0][DATA_W-1:0] buf_words;
    logic [HP_WORDS-1:0][DATA_W-1:0] asm_words;
    logic                            beat_is_word, is_final, is_erase;
    logic [ADDR_W-1:0]               chk_addr;
    logic                            prot_hit, slot_free;
    logic                            acc, drop, launch_prog, launch_erase, cfg_acc;

    nvs_op_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tmr_start),
        .load_val (tmr_load),
        .done     (tmr_done)
    );

    nvs_load_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HP_WORDS(HP_WORDS)) i_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (buf_push),
        .clear     (buf_clear),
        .addr_in   (wr_addr),
        .word_in   (wr_data),
        .cnt       (buf_cnt),
        .base_addr (buf_base),
        .words     (buf_words)
    );

    nvs_prot_check #(.SECT_W(SECT_W)) i_prot (
        .sector   (chk_addr[ADDR_W-1 -: SECT_W]),
        .prot_map (seq_q.prot),
        .hit      (prot_hit)
    );

    // burst image: buffered words followed by the beat on the bus
    for (genvar i = 0; i < HP_WORDS; i++) begin : g_asm
        if (i < HP_WORDS - 1) begin : g_buf
            assign asm_words[i] = buf_words[i];
        end else begin : g_bus
            assign asm_words[i] = wr_data;
        end
    end

    // beat classification
    always_comb begin
        beat_is_word = (buf_cnt != '0) || (wr_op == OP_HALF);
        is_erase     = !beat_is_word && (wr_op == OP_ERASE);
        is_final     = beat_is_word ? (buf_cnt == LAST_IDX) : !is_erase;
        chk_addr     = (buf_cnt != '0) ? buf_base : wr_addr;
        slot_free    = (seq_q.state == ST_IDLE) || ((seq_q.state == ST_PROG) && tmr_done);
    end

    // acceptance decision
    always_comb begin
        if (seq_q.state == ST_ERASE) wr_ready = 1'b0;
        else if (is_erase)           wr_ready = (seq_q.state == ST_IDLE);
        else if (!is_final)          wr_ready = 1'b1;
        else if (prot_hit)           wr_ready = 1'b1;
        else                         wr_ready = slot_free;

        cfg_ready    = (seq_q.state != ST_ERASE) && (buf_cnt == '0);
        acc          = wr_valid && wr_ready;
        cfg_acc      = cfg_valid && cfg_ready;
        buf_push     = acc && beat_is_word && !is_final;
        buf_clear    = acc && beat_is_word && is_final;
        drop         = acc && is_final && prot_hit;
        launch_prog  = acc && is_final && !prot_hit;
        launch_erase = acc && is_erase;
        tmr_start    = launch_prog || launch_erase;
        tmr_load     = launch_erase ? ERASE_LOAD : PROG_LOAD;
    end

    // next-state computation
    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        seq_d.held  = wr_valid && !wr_ready && is_final && !prot_hit &&
                      (seq_q.state == ST_PROG);

        if (tmr_done) seq_d.state = ST_IDLE;

        if (launch_prog) begin
            seq_d.state = ST_PROG;
            seq_d.start = 1'b1;
            seq_d.addr  = chk_addr;
            if (beat_is_word) begin
                seq_d.op    = OP_HALF;
                seq_d.wdata = asm_words;
            end else begin
                seq_d.op    = OP_SINGLE;
                seq_d.wdata = {{(WIDE_W - DATA_W){1'b0}}, wr_data};
            end
        end else if (launch_erase) begin
            seq_d.state = ST_ERASE;
            seq_d.start = 1'b1;
            seq_d.op    = OP_ERASE;
            seq_d.addr  = wr_addr;
            seq_d.wdata = '0;
        end

        if (cfg_acc) begin
            if (!cfg_sel)          seq_d.prot = cfg_wdata;
            else if (cfg_wdata[0]) seq_d.err  = 1'b0;
        end
        if (drop) seq_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy      = (seq_q.state != ST_IDLE);
    assign erasing   = (seq_q.state == ST_ERASE);
    assign held      = seq_q.held;
    assign wrp_err   = seq_q.err;
    assign nvm_start = seq_q.start;
    assign nvm_op    = seq_q.op;
    assign nvm_addr  = seq_q.addr;
    assign nvm_wdata = seq_q.wdata;

    AST_ERASE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        erasing |-> !(wr_valid && wr_ready)); // R7
    AST_ERASE_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        erasing |-> !(cfg_valid && cfg_ready)); // R7
    AST_ERASE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (nvm_start && (nvm_op == 2'd2)) |-> !$past(busy)); // R6
    AST_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> busy); // R5
    AST_HOLD_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> busy); // R5
    AST_DROP_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !tmr_done) |=> (busy == $past(busy))); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wrp_err && !(cfg_valid && cfg_ready && cfg_sel && cfg_wdata[0])) |=> wrp_err); // R9
endmodule

// File: tb/test_nvs_write_seq.sv
module test_nvs_write_seq;
    localparam int AW = 16, DW = 32, HPW = 4, SW = 3, PC = 20, EC = 40;
    localparam int NS = 1 << SW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [1:0] wr_op = 2'd0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic wr_ready;
    logic cfg_valid = 1'b0, cfg_sel = 1'b0;
    logic [NS-1:0] cfg_wdata = '0;
    logic cfg_ready, busy, erasing, held, wrp_err, nvm_start;
    logic [1:0] nvm_op;
    logic [AW-1:0] nvm_addr;
    logic [HPW*DW-1:0] nvm_wdata;

    int total = 0, bad = 0;
    int stalls, n;
    bit saw_held, busy_gap, finished = 0;

    always #10 clk = ~clk;

    nvs_write_seq #(.ADDR_W(AW), .DATA_W(DW), .HP_WORDS(HPW), .SECT_W(SW),
                    .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) i_nvs_write_seq (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_op(wr_op),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .cfg_valid(cfg_valid), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_ready(cfg_ready), .busy(busy), .erasing(erasing), .held(held),
        .wrp_err(wrp_err), .nvm_start(nvm_start), .nvm_op(nvm_op),
        .nvm_addr(nvm_addr), .nvm_wdata(nvm_wdata));

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic beat(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_valid = 1'b1; wr_op = op; wr_addr = a; wr_data = d;
        stalls = 0; saw_held = 0; busy_gap = 0;
        #1;
        while (!wr_ready) begin
            @(negedge clk); stalls++;
            if (held) saw_held = 1;
            if (!busy) busy_gap = 1;
            #1;
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic cfg_write(input logic sel, input logic [NS-1:0] w);
        cfg_valid = 1'b1; cfg_sel = sel; cfg_wdata = w; stalls = 0;
        #1;
        while (!cfg_ready) begin
            @(negedge clk); stalls++; #1;
        end
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic wait_idle();
        n = 0;
        while (busy) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "erasing", erasing, 0);
        chk("R1", "held", held, 0);
        chk("R1", "wrp_err", wrp_err, 0);
        chk("R1", "nvm_start", nvm_start, 0);
        chk("R1", "wr_ready", wr_ready, 1);
        chk("R1", "cfg_ready", cfg_ready, 1);
    endtask

    task automatic t_single();
        beat(2'd0, 16'h2010, 32'hCAFE0001);
        chk("R2", "stalls", stalls, 0);
        chk("R2", "start", nvm_start, 1);
        chk("R2", "op", nvm_op, 0);
        chk("R2", "addr", nvm_addr, 16'h2010);
        chk("R2", "word0", nvm_wdata[DW-1:0], 32'hCAFE0001);
        chk("R2", "upper zero", nvm_wdata[HPW*DW-1:DW] == '0, 1);
        wait_idle();
        chk("R2", "busy length", n, PC);
    endtask

    task automatic t_burst();
        beat(2'd1, 16'h4100, 32'h11110000);
        chk("R8", "cfg blocked mid burst", cfg_ready, 0);
        for (int i = 1; i < HPW; i++) begin
            beat(2'd0, 16'h0000, 32'h11110000 + i);
            chk("R3", "no stall", stalls, 0);
        end
        chk("R3", "start", nvm_start, 1);
        chk("R3", "op", nvm_op, 1);
        chk("R3", "addr", nvm_addr, 16'h4100);
        for (int i = 0; i < HPW; i++)
            chk("R3", "word", nvm_wdata[i*DW +: DW], 32'h11110000 + i);
        chk("R8", "cfg free after burst", cfg_ready, 1);
        wait_idle();
    endtask

    task automatic t_protect();
        cfg_write(1'b0, 8'b0010_0000);              // sector 5 protected
        beat(2'd0, 16'hA004, 32'h1);
        chk("R4", "stalls", stalls, 0);
        chk("R4", "no start", nvm_start, 0);
        chk("R4", "err set", wrp_err, 1);
        chk("R4", "busy unchanged", busy, 0);
        cfg_write(1'b1, 8'h00);
        chk("R9", "err stays", wrp_err, 1);
        cfg_write(1'b1, 8'h01);
        chk("R9", "err cleared", wrp_err, 0);
        for (int i = 0; i < HPW; i++) beat(2'd1, 16'hA200, 32'h5);
        chk("R4", "burst no start", nvm_start, 0);
        chk("R4", "burst err", wrp_err, 1);
        cfg_write(1'b1, 8'h01);
        // protected write while a program runs
        beat(2'd0, 16'h2000, 32'h7);
        beat(2'd0, 16'hA000, 32'h8);
        chk("R4", "drop stalls", stalls, 0);
        chk("R4", "drop err", wrp_err, 1);
        chk("R4", "still busy", busy, 1);
        chk("R4", "no restart", nvm_start, 0);
        wait_idle();
        chk("R4", "first unaffected", n, PC - 1);
        cfg_write(1'b1, 8'h01);
    endtask

    task automatic t_held();
        beat(2'd0, 16'h2100, 32'hA);
        cfg_write(1'b0, 8'b0010_0000);
        chk("R8", "cfg during program", stalls, 0);
        wait_idle();
        beat(2'd0, 16'h2200, 32'hB);
        beat(2'd0, 16'h2300, 32'hC);
        chk("R5", "held stall", stalls, PC - 1);
        chk("R5", "held seen", saw_held, 1);
        chk("R5", "busy no gap", busy_gap, 0);
        chk("R5", "second start", nvm_start, 1);
        chk("R5", "second addr", nvm_addr, 16'h2300);
        chk("R5", "held cleared", held, 0);
        wait_idle();
        chk("R5", "second length", n, PC);
        beat(2'd0, 16'h2400, 32'hD);
        for (int i = 0; i < HPW; i++) beat(2'd1, 16'h6000, 32'h900 + i);
        chk("R3", "final stall", stalls, PC - HPW);
        chk("R3", "held burst op", nvm_op, 1);
        chk("R3", "held burst last", nvm_wdata[(HPW-1)*DW +: DW], 32'h900 + HPW - 1);
        wait_idle();
    endtask

    task automatic t_erase();
        beat(2'd0, 16'h2000, 32'h1);
        beat(2'd2, 16'h0000, 32'h0);
        chk("R10", "erase waits idle", stalls, PC);
        chk("R6", "start", nvm_start, 1);
        chk("R6", "op", nvm_op, 2);
        chk("R6", "erasing", erasing, 1);
        cfg_write(1'b0, 8'h00);
        chk("R7", "cfg stalled", stalls, EC);
        chk("R6", "erase done", erasing, 0);
        beat(2'd2, 16'h0000, 32'h0);
        chk("R6", "idle erase no stall", stalls, 0);
        beat(2'd0, 16'h2000, 32'h2);
        chk("R7", "write stalled", stalls, EC);
        chk("R7", "write starts after", nvm_op, 0);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_protect();
        t_held();
        t_erase();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        report();
    end
endmodule